// File: doc/BRIEF.md
# Duration-Driven Block Fetch Sequencer

This block steers instruction fetch through a chain of predicted code blocks. Each prediction gives the length of the block that is about to run and the offset, in cache lines, from that block's entry to the next block. The length has three fields: a count of whole lines, a count of instructions in a final partial line, and a count of taken calls. The sequencer accepts a prediction and tells the prefetcher where the block starts and how many lines to bring in. It then issues exactly the predicted number of instruction slots, one per cycle, as a line address and a slot index. It waits until the decoder has reported all the predicted taken calls. It then flags the end of the block and takes the next prediction in that same cycle, so consecutive blocks run without a bubble.

A block longer than the normal line field can express uses a logarithmic form. Such a block is fetched and issued in full and then held until a correction arrives, because it can only end in a mispredict. A redirect input drops whatever is in flight, loads the corrected entry address and waits out a fixed mispredict penalty. After that it draws a fresh prediction for the corrected address.

Top module: `fetch_seq`

## Requirements
- R1: With pred_long low, a block whose line field is L and whose tail field is I issues L*4+I slots (4 slots per line, slot index 2 bits). A zero duration is raised to one slot. Slots go out on consecutive cycles, starting the cycle after acceptance at the block base line with slot 0, and advance slot 0..3 before moving to the next line.
- R2: In the cycle a prediction is accepted (pred_valid and pred_ready both high), pf_valid is high, pf_addr equals the block base and pf_lines equals L plus one if I is nonzero, with a minimum of 1.
- R3: The block does not end until pred_calls call_taken pulses have been seen while the block is active. If calls are still outstanding after the last slot, issue stops and blk_end rises in the cycle the final pulse arrives. Pulses beyond the predicted count, and pulses while no block is active, have no effect.
- R4: blk_end is high for one cycle when a block completes, and pred_ready is high in that same cycle. The next block's base is the previous base plus that block's pred_off, modulo 2^16. If pred_valid is high in the end cycle, the next block issues its first slot in the following cycle.
- R5: When no prediction is offered, the sequencer idles with issue_valid and pf_valid low and pred_ready high, and it neither issues nor advances.
- R6: With pred_long high, the line count is 2^L, the tail field is ignored, pf_lines equals 2^L, and 2^L*4 slots issue. After that, issue_valid, blk_end and pred_ready stay low until a redirect.
- R7: In a redirect cycle issue_valid, pf_valid, blk_end and pred_ready are low. fetch_flush is high in the next cycle. For the 5 cycles after the redirect nothing issues and pred_ready stays low. After that, the next accepted block has base redirect_addr.
- R8: After reset issue_valid, blk_end, pf_valid and fetch_flush are low, pred_ready is high and the first block's base is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Next prediction in the chain is available |
| pred_ready | output | 1 | Sequencer can take a prediction this cycle |
| pred_off | input | 16 | Line offset from this block's base to the next block |
| pred_lines | input | 3 | Whole-line count, or log2 of the lines in long form |
| pred_insts | input | 2 | Instructions in the final partial line |
| pred_calls | input | 2 | Taken calls expected in the block |
| pred_long | input | 1 | Line field uses the logarithmic long form |
| call_taken | input | 1 | Decoder reports one taken call |
| redirect | input | 1 | Correction: restart at redirect_addr |
| redirect_addr | input | 16 | Corrected entry line address |
| issue_valid | output | 1 | A slot is issued to fetch/decode |
| issue_line | output | 16 | Line address of the issued slot |
| issue_slot | output | 2 | Slot index inside the line |
| blk_end | output | 1 | Current block completes this cycle |
| pf_valid | output | 1 | Prefetch request for a new block |
| pf_addr | output | 16 | First line of the prefetch |
| pf_lines | output | 8 | Number of lines to prefetch |
| fetch_flush | output | 1 | Drop all fetches in flight |

## Verification
The bench builds the default configuration: 16-bit line addresses, a 3-bit line field, 4 slots per line, a 2-bit call count and a 5-cycle penalty. With these values every normal line and tail combination (32 blocks) is run in full. The bench also covers the long form for log line counts 0 to 3, which includes a block spanning 8 lines, and every call count up to the field's maximum. Calls arrive both during issue and after the last slot. The narrow fields keep each sweep short enough to compare every issued line and slot against arithmetic expectations.

// File: rtl/fsq_pkg.sv
package fsq_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE  = 3'd0,
    SQ_RUN   = 3'd1,
    SQ_CALLS = 3'd2,
    SQ_HOLD  = 3'd3,
    SQ_PEN   = 3'd4
  } seq_state_e;
endpackage

// File: rtl/fsq_dur.sv
// Turns the predicted duration fields into a slot count and a prefetch line count.
module fsq_dur #(
  parameter int LINE_W = 3,
  parameter int SLOT_W = 2,
  parameter int PF_W   = 8,
  parameter int CNT_W  = 10
) (
  input  logic [LINE_W-1:0] lines_f,
  input  logic [SLOT_W-1:0] tail_f,
  input  logic              long_f,
  output logic [CNT_W-1:0]  n_slots,
  output logic [PF_W-1:0]   n_lines
);
  logic [PF_W-1:0]   line_cnt;
  logic [SLOT_W-1:0] tail;
  logic [CNT_W-1:0]  raw_slots;
  logic [PF_W-1:0]   raw_lines;

  always_comb begin
    if (long_f) begin
      line_cnt = PF_W'(1) << lines_f;
      tail     = '0;
    end else begin
      line_cnt = PF_W'(lines_f);
      tail     = tail_f;
    end
    raw_slots = (CNT_W'(line_cnt) << SLOT_W) + CNT_W'(tail);
    raw_lines = line_cnt + PF_W'(tail != '0);
    n_slots   = (raw_slots == '0) ? CNT_W'(1) : raw_slots;
    n_lines   = (raw_lines == '0) ? PF_W'(1) : raw_lines;
  end
endmodule

// File: rtl/fsq_pos.sv
// Position counter: line index, slot index and remaining slots of the block.
module fsq_pos #(
  parameter int SLOT_W = 2,
  parameter int PF_W   = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [CNT_W-1:0]  n_slots,
  output logic [PF_W-1:0]   line_idx,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              last
);
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [PF_W-1:0]   ln_q, ln_d;
  logic [SLOT_W-1:0] sl_q, sl_d;
  logic              en;

  assign en = load | adv;

  always_comb begin
    rem_d = rem_q;
    ln_d  = ln_q;
    sl_d  = sl_q;
    if (load) begin
      rem_d = n_slots;
      ln_d  = '0;
      sl_d  = '0;
    end else if (adv) begin
      rem_d = rem_q - CNT_W'(1);
      sl_d  = sl_q + SLOT_W'(1);
      if (&sl_q) ln_d = ln_q + PF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      ln_q  <= '0;
      sl_q  <= '0;
    end else if (en) begin
      rem_q <= rem_d;
      ln_q  <= ln_d;
      sl_q  <= sl_d;
    end
  end

  assign line_idx = ln_q;
  assign slot_idx = sl_q;
  assign last     = (rem_q == CNT_W'(1));
endmodule

// File: rtl/fsq_ctrl.sv
// Sequencing control: block state, call tally, chain addresses, penalty timer.
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CALL_W   = 2,
  parameter int MISS_CYC = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  input  logic [ADDR_W-1:0] pred_off,
  input  logic [CALL_W-1:0] pred_calls,
  input  logic              pred_long,
  input  logic              call_taken,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  input  logic              last,
  output logic              pred_ready,
  output logic              take,
  output logic              issue,
  output logic              blk_end,
  output logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] entry,
  output logic              fetch_flush
);
  localparam int PEN_W = $clog2(MISS_CYC + 1);

  seq_state_e        st_q, st_d;
  logic [ADDR_W-1:0] entry_q, entry_d, nxt_q, nxt_d;
  logic [CALL_W-1:0] rcall_q, rcall_d;
  logic              long_q, long_d;
  logic [PEN_W-1:0]  pen_q, pen_d;
  logic              flush_q;
  logic              calls_done, end_now, accept, addr_en, active;

  assign active     = (st_q == SQ_RUN) || (st_q == SQ_CALLS);
  assign calls_done = (rcall_q == '0) || ((rcall_q == CALL_W'(1)) && call_taken);

  always_comb begin
    end_now = 1'b0;
    if (!redirect) begin
      unique case (st_q)
        SQ_RUN:   end_now = last && !long_q && calls_done;
        SQ_CALLS: end_now = calls_done;
        default:  end_now = 1'b0;
      endcase
    end
  end

  assign issue     = (st_q == SQ_RUN) && !redirect;
  assign accept    = !redirect && ((st_q == SQ_IDLE) || end_now);
  assign take      = accept && pred_valid;
  assign base_addr = (st_q == SQ_IDLE) ? entry_q : nxt_q;

  always_comb begin
    st_d    = st_q;
    entry_d = entry_q;
    nxt_d   = nxt_q;
    rcall_d = rcall_q;
    long_d  = long_q;
    pen_d   = pen_q;
    if (active && call_taken && (rcall_q != '0)) rcall_d = rcall_q - CALL_W'(1);
    if (redirect) begin
      st_d    = SQ_PEN;
      entry_d = redirect_addr;
      pen_d   = PEN_W'(MISS_CYC);
    end else begin
      unique case (st_q)
        SQ_IDLE: ;
        SQ_RUN: begin
          if (last) begin
            if (long_q)          st_d = SQ_HOLD;
            else if (!calls_done) st_d = SQ_CALLS;
          end
        end
        SQ_CALLS: ;
        SQ_HOLD: ;
        SQ_PEN: begin
          if (pen_q == PEN_W'(1)) st_d = SQ_IDLE;
          else                    pen_d = pen_q - PEN_W'(1);
        end
        default: st_d = SQ_IDLE;
      endcase
      if (end_now) begin
        st_d    = SQ_IDLE;
        entry_d = nxt_q;
      end
      if (take) begin
        st_d    = SQ_RUN;
        entry_d = base_addr;
        nxt_d   = base_addr + pred_off;
        rcall_d = pred_calls;
        long_d  = pred_long;
      end
    end
  end

  assign addr_en = redirect || take || end_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SQ_IDLE;
      pen_q   <= '0;
      rcall_q <= '0;
      flush_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pen_q   <= pen_d;
      rcall_q <= rcall_d;
      flush_q <= redirect;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      nxt_q   <= '0;
      long_q  <= 1'b0;
    end else if (addr_en) begin
      entry_q <= entry_d;
      nxt_q   <= nxt_d;
      long_q  <= long_d;
    end
  end

  assign pred_ready  = accept;
  assign blk_end     = end_now;
  assign entry       = entry_q;
  assign fetch_flush = flush_q;
endmodule

// File: rtl/fetch_seq.sv
module fetch_seq #(
  parameter int ADDR_W   = 16,
  parameter int LINE_W   = 3,
  parameter int SLOT_W   = 2,
  parameter int CALL_W   = 2,
  parameter int MISS_CYC = 5,
  localparam int PF_W    = 1 << LINE_W,
  localparam int CNT_W   = PF_W + SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pred_valid,
  output logic              pred_ready,
  input  logic [ADDR_W-1:0] pred_off,
  input  logic [LINE_W-1:0] pred_lines,
  input  logic [SLOT_W-1:0] pred_insts,
  input  logic [CALL_W-1:0] pred_calls,
  input  logic              pred_long,
  input  logic              call_taken,
  input  logic              redirect,
  input  logic [ADDR_W-1:0] redirect_addr,
  output logic              issue_valid,
  output logic [ADDR_W-1:0] issue_line,
  output logic [SLOT_W-1:0] issue_slot,
  output logic              blk_end,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [PF_W-1:0]   pf_lines,
  output logic              fetch_flush
);
  logic [CNT_W-1:0]  n_slots;
  logic [PF_W-1:0]   n_lines;
  logic [PF_W-1:0]   line_idx;
  logic [ADDR_W-1:0] base_addr, entry;
  logic              take, issue, last;

  fsq_dur #(.LINE_W(LINE_W), .SLOT_W(SLOT_W), .PF_W(PF_W), .CNT_W(CNT_W)) u_dur (
    .lines_f (pred_lines),
    .tail_f  (pred_insts),
    .long_f  (pred_long),
    .n_slots (n_slots),
    .n_lines (n_lines)
  );

  fsq_pos #(.SLOT_W(SLOT_W), .PF_W(PF_W), .CNT_W(CNT_W)) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (take),
    .adv      (issue),
    .n_slots  (n_slots),
    .line_idx (line_idx),
    .slot_idx (issue_slot),
    .last     (last)
  );

  fsq_ctrl #(.ADDR_W(ADDR_W), .CALL_W(CALL_W), .MISS_CYC(MISS_CYC)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_valid    (pred_valid),
    .pred_off      (pred_off),
    .pred_calls    (pred_calls),
    .pred_long     (pred_long),
    .call_taken    (call_taken),
    .redirect      (redirect),
    .redirect_addr (redirect_addr),
    .last          (last),
    .pred_ready    (pred_ready),
    .take          (take),
    .issue         (issue),
    .blk_end       (blk_end),
    .base_addr     (base_addr),
    .entry         (entry),
    .fetch_flush   (fetch_flush)
  );

  assign issue_valid = issue;
  assign issue_line  = entry + ADDR_W'(line_idx);
  assign pf_valid    = take;
  assign pf_addr     = base_addr;
  assign pf_lines    = n_lines;
endmodule

// File: rtl/fetch_seq_chk.sv
module fetch_seq_chk #(
  parameter int ADDR_W   = 16,
  parameter int SLOT_W   = 2,
  parameter int PF_W     = 8,
  parameter int MISS_CYC = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pred_valid,
  input logic              pred_ready,
  input logic              redirect,
  input logic              issue_valid,
  input logic [ADDR_W-1:0] issue_line,
  input logic [SLOT_W-1:0] issue_slot,
  input logic              blk_end,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic [PF_W-1:0]   pf_lines,
  input logic              fetch_flush
);
  localparam int WIN_W = $clog2(MISS_CYC + 1);
  logic [WIN_W-1:0] win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             win_q <= '0;
    else if (redirect)      win_q <= WIN_W'(MISS_CYC);
    else if (win_q != '0)   win_q <= win_q - WIN_W'(1);
  end

  p_pf_on_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_valid && pred_ready) |-> (pf_valid && (pf_lines != '0)));

  p_first_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !redirect) |=> (redirect || (issue_valid && (issue_slot == '0) && (issue_line == $past(pf_addr)))));

  p_slot_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && $past(issue_valid) && !$past(pf_valid)) |->
      ({issue_line, issue_slot} == ($past({issue_line, issue_slot}) + 1'b1)));

  p_end_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |-> pred_ready);

  p_flush_next_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> fetch_flush);

  p_redirect_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!issue_valid && !pred_ready && !pf_valid && !blk_end));

  p_penalty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q != '0) |-> (!issue_valid && !pred_ready && !blk_end));
endmodule

bind fetch_seq fetch_seq_chk #(
  .ADDR_W(ADDR_W), .SLOT_W(SLOT_W), .PF_W(PF_W), .MISS_CYC(MISS_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
  .redirect(redirect), .issue_valid(issue_valid), .issue_line(issue_line),
  .issue_slot(issue_slot), .blk_end(blk_end), .pf_valid(pf_valid),
  .pf_addr(pf_addr), .pf_lines(pf_lines), .fetch_flush(fetch_flush)
);

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
module sim_fetch_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pred_valid, pred_ready, pred_long, call_taken, redirect;
  logic [15:0] pred_off, redirect_addr, issue_line, pf_addr;
  logic [2:0]  pred_lines;
  logic [1:0]  pred_insts, pred_calls, issue_slot;
  logic        issue_valid, blk_end, pf_valid, fetch_flush;
  logic [7:0]  pf_lines;

  int checks = 0;
  int errors = 0;
  logic [15:0] exp_base;
  bit done = 0;

  always #5 clk = ~clk;

  fetch_seq u0 (
    .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_ready(pred_ready),
    .pred_off(pred_off), .pred_lines(pred_lines), .pred_insts(pred_insts),
    .pred_calls(pred_calls), .pred_long(pred_long), .call_taken(call_taken),
    .redirect(redirect), .redirect_addr(redirect_addr), .issue_valid(issue_valid),
    .issue_line(issue_line), .issue_slot(issue_slot), .blk_end(blk_end),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_lines(pf_lines), .fetch_flush(fetch_flush)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_pred(input logic [15:0] off, input int l, input int i, input int c, input bit lg);
    pred_off   = off;
    pred_lines = 3'(l);
    pred_insts = 2'(i);
    pred_calls = 2'(c);
    pred_long  = lg;
  endtask

  // One block from idle: early calls during issue, 'late' calls after the last slot.
  task automatic do_block(input logic [15:0] off, input int l, input int i, input int c,
                          input int late, input bit extra, input bit lg);
    int n, pfl;
    if (lg) begin
      pfl = 1 << l; n = pfl * 4;
    end else begin
      n = l * 4 + i; if (n == 0) n = 1;
      pfl = l + ((i != 0) ? 1 : 0); if (pfl == 0) pfl = 1;
    end
    @(negedge clk);
    pred_valid = 1'b1; set_pred(off, l, i, c, lg); call_taken = 1'b0;
    #2;
    chk("R5 ready on offer", pred_ready, 1);
    chk("R2 pf_valid", pf_valid, 1);
    chk("R2 pf_addr", pf_addr, exp_base);
    chk("R2/R6 pf_lines", pf_lines, pfl);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      pred_valid = 1'b0;
      call_taken = extra || (k < (c - late));
      #2;
      chk("R1 issue_valid", issue_valid, 1);
      chk("R1 issue_line", issue_line, 16'(exp_base + 16'(k / 4)));
      chk("R1 issue_slot", issue_slot, k % 4);
      chk("R3 blk_end timing", blk_end, (k == n - 1) && (late == 0) && !lg);
    end
    if (lg) begin
      for (int h = 0; h < 3; h++) begin
        @(negedge clk);
        pred_valid = 1'b1; call_taken = 1'b0;
        #2;
        chk("R6 hold no issue", issue_valid, 0);
        chk("R6 hold no end", blk_end, 0);
        chk("R6 hold not ready", pred_ready, 0);
      end
      pred_valid = 1'b0;
    end else begin
      for (int j = 0; j < late; j++) begin
        @(negedge clk);
        call_taken = 1'b0;
        #2;
        chk("R3 wait for calls no issue", issue_valid, 0);
        chk("R3 wait for calls no end", blk_end, 0);
        chk("R3 wait not ready", pred_ready, 0);
        @(negedge clk);
        call_taken = 1'b1;
        #2;
        chk("R3 end on final call", blk_end, j == late - 1);
      end
      @(negedge clk);
      call_taken = 1'b0;
      #2;
      chk("R5 idle ready", pred_ready, 1);
      chk("R5 idle no issue", issue_valid, 0);
      chk("R5 idle no prefetch", pf_valid, 0);
      exp_base = exp_base + off;
    end
  endtask

  task automatic do_redirect(input logic [15:0] addr);
    @(negedge clk);
    redirect = 1'b1; redirect_addr = addr; pred_valid = 1'b1; set_pred(16'd9, 0, 1, 0, 1'b0);
    #2;
    chk("R7 masked issue", issue_valid, 0);
    chk("R7 masked ready", pred_ready, 0);
    chk("R7 masked prefetch", pf_valid, 0);
    @(negedge clk);
    redirect = 1'b0;
    #2;
    chk("R7 flush", fetch_flush, 1);
    chk("R7 penalty ready", pred_ready, 0);
    for (int p = 1; p < 5; p++) begin
      @(negedge clk);
      #2;
      chk("R7 penalty ready", pred_ready, 0);
      chk("R7 penalty issue", issue_valid, 0);
      chk("R7 flush one cycle", fetch_flush, 0);
    end
    @(negedge clk);
    pred_valid = 1'b0;
    #2;
    chk("R7 ready after penalty", pred_ready, 1);
    exp_base = addr;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pred_valid = 1'b0; call_taken = 1'b0; redirect = 1'b0;
    redirect_addr = '0; set_pred('0, 0, 0, 0, 1'b0);
    exp_base = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R8 reset state
    chk("R8 issue_valid", issue_valid, 0);
    chk("R8 blk_end", blk_end, 0);
    chk("R8 pf_valid", pf_valid, 0);
    chk("R8 fetch_flush", fetch_flush, 0);
    chk("R8 pred_ready", pred_ready, 1);

    // R1/R2/R4/R8: full sweep of normal durations, chain offsets vary
    for (int l = 0; l < 8; l++)
      for (int i = 0; i < 4; i++)
        do_block(16'(l * 3 + i + 1), l, i, 0, 0, 1'b0, 1'b0);

    // R3: calls during issue, after issue, and surplus calls
    do_block(16'd5, 1, 1, 3, 0, 1'b0, 1'b0);
    do_block(16'd2, 0, 1, 2, 2, 1'b0, 1'b0);
    do_block(16'd7, 0, 3, 3, 1, 1'b0, 1'b0);
    do_block(16'd1, 0, 2, 0, 0, 1'b1, 1'b0);
    do_block(16'd3, 0, 3, 1, 0, 1'b1, 1'b0);
    // R3: calls while idle are ignored
    @(negedge clk); call_taken = 1'b1;
    @(negedge clk); call_taken = 1'b1;
    #2; chk("R3 idle calls no issue", issue_valid, 0);
    @(negedge clk); call_taken = 1'b0;
    do_block(16'd4, 0, 2, 1, 1, 1'b0, 1'b0);

    // R4: back-to-back blocks with no bubble
    begin
      logic [15:0] base_b;
      @(negedge clk);
      pred_valid = 1'b1; set_pred(16'd6, 0, 2, 0, 1'b0);
      #2; chk("R2 pf_addr A", pf_addr, exp_base);
      @(negedge clk);
      pred_valid = 1'b0;
      #2; chk("R1 A slot0", issue_slot, 0);
      @(negedge clk);
      pred_valid = 1'b1; set_pred(16'd2, 1, 0, 0, 1'b0);
      base_b = exp_base + 16'd6;
      #2;
      chk("R4 end A", blk_end, 1);
      chk("R4 ready at end", pred_ready, 1);
      chk("R4 chained pf_addr", pf_addr, base_b);
      chk("R4 chained pf_lines", pf_lines, 1);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        pred_valid = 1'b0;
        #2;
        chk("R4 no bubble issue", issue_valid, 1);
        chk("R4 B line", issue_line, base_b);
        chk("R4 B slot", issue_slot, k);
      end
      @(negedge clk);
      #2; chk("R5 idle after B", pred_ready, 1);
      exp_base = base_b + 16'd2;
    end

    // R5: stall while no prediction offered
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      #2;
      chk("R5 stall no issue", issue_valid, 0);
      chk("R5 stall ready", pred_ready, 1);
    end
    do_block(16'd1, 0, 1, 0, 0, 1'b0, 1'b0);

    // R6/R7: long-form blocks, each closed by a redirect
    for (int l = 0; l < 4; l++) begin
      do_block(16'd3, l, 3, 0, 0, 1'b0, 1'b1);
      do_redirect(16'(16'h1000 + l * 16'h40));
      do_block(16'd2, 0, 2, 0, 0, 1'b0, 1'b0);
    end

    // R7: redirect in the middle of a block
    @(negedge clk);
    pred_valid = 1'b1; set_pred(16'd8, 2, 0, 0, 1'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      pred_valid = 1'b0;
      #2; chk("R1 partial issue", issue_valid, 1);
    end
    do_redirect(16'hFFFE);
    do_block(16'd3, 1, 2, 0, 0, 1'b0, 1'b0);
    chk("R4 wrap base", exp_base, 16'h0001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule